// File: doc/BRIEF.md
# Interrupt Request Flag Controller

This block keeps the pending-request flags for six interrupt sources of a small 8-bit controller. It presents them as two byte-wide special-function registers. The first is a timer/external control register. It holds two timer overflow flags, two external request flags, the trigger-mode bit of each external pin and two plain storage bits. The second is an auxiliary register with two extra external request flags. The registers are always visible on read outputs. A write strobe per register loads a data byte.

Each timer flag is set by a one-cycle rollover pulse. It is cleared when the interrupt controller acknowledges that source with its ID. The two active-low external pins pass through a synchroniser. Each pin is then tracked by a two-state edge machine, with states PIN_HIGH and PIN_LOW. The transition PIN_HIGH→PIN_LOW marks a falling edge, and PIN_LOW→PIN_HIGH re-arms the detector. In edge mode a falling edge latches the flag and the acknowledge clears it. In level mode the flag simply mirrors the inverted pin.

Every flag is a two-state machine with states FLAG_IDLE and FLAG_PEND. IDLE→PEND is taken on a hardware set, on a software write of 1, or on a low pin in level mode. PEND→IDLE is taken on a software write of 0, on an acknowledge, or on a high pin in level mode. One request line per source mirrors its flag.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, `tcon_q` reads 0x00, `aux_q` reads 0x00 and all `irq_req` lines are 0.
- R2: A pulse on `tmr0_ovf` / `tmr1_ovf` sets `tcon_q[5]` / `tcon_q[7]` at the next rising clock edge.
- R3: An acknowledge (`ack_valid`=1) whose `ack_src` is 1 clears `tcon_q[5]`, and one whose `ack_src` is 3 clears `tcon_q[7]`. IDs 6 and 7 clear no flag.
- R4: With `tcon_q[0]`=1 (pin 0) or `tcon_q[2]`=1 (pin 1), the pin is in edge mode. In that mode a 1→0 change on `ext0_pin_n` / `ext1_pin_n` sets `tcon_q[1]` / `tcon_q[3]` at the third rising edge after the change. Each edge sets the flag exactly once, however long the pin then stays low.
- R5: In edge mode, an acknowledge with ID 0 clears `tcon_q[1]`, and one with ID 2 clears `tcon_q[3]`.
- R6: With the mode bit at 0 (level mode), the flag equals the inverted pin, with a latency of three rising edges. Acknowledges and software writes to that flag have no effect.
- R7: `aux_q[0]` / `aux_q[1]` are set by a pulse on `ext2_req` / `ext3_req`. They are cleared only by a software write, and an acknowledge leaves them unchanged. `aux_q[7:2]` always read 0.
- R8: If a hardware set and a software write or an acknowledge hit the same flag in one cycle, the flag ends set. A software write takes precedence over an acknowledge.
- R9: A write to the timer/external register loads bits 0, 2, 4 and 6 directly from `sfr_wdata`. It loads the flag bits 1, 3, 5 and 7 subject to R6 and R8.
- R10: `irq_req[i]` equals the flag of source ID i. The order is 0 = `tcon_q[1]`, 1 = `tcon_q[5]`, 2 = `tcon_q[3]`, 3 = `tcon_q[7]`, 4 = `aux_q[0]`, 5 = `aux_q[1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| tmr0_ovf | input | 1 | Timer 0 rollover pulse |
| tmr1_ovf | input | 1 | Timer 1 rollover pulse |
| ext0_pin_n | input | 1 | External request pin 0, active low, asynchronous |
| ext1_pin_n | input | 1 | External request pin 1, active low, asynchronous |
| ext2_req | input | 1 | Auxiliary request 2 pulse |
| ext3_req | input | 1 | Auxiliary request 3 pulse |
| ack_valid | input | 1 | Vector acknowledge strobe |
| ack_src | input | 3 | Source ID being vectored |
| sfr_wr_tcon | input | 1 | Write strobe, timer/external register |
| sfr_wr_aux | input | 1 | Write strobe, auxiliary register |
| sfr_wdata | input | 8 | Write data byte |
| tcon_q | output | 8 | Timer/external register contents |
| aux_q | output | 8 | Auxiliary register contents |
| irq_req | output | 6 | Request line per source ID |

## Verification
Strobes, pulses and acknowledges take effect at the first rising edge after they are driven. Pin changes reach a flag at the third edge, because they pass two synchroniser stages and then the flag register. The bench drives inputs on the falling edge. It advances a reference model on the same rising edge as the design and compares all outputs one time unit after that edge. The pin latency therefore shows up in the model's own three-stage pipeline and not as a guessed wait. The directed cases also count edges explicitly. They confirm that a flag is still clear after two edges and set after the third.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
    localparam int NUM_SRC = 6;
    localparam int SRC_W   = 3;

    typedef enum logic {
        FLAG_IDLE,
        FLAG_PEND
    } flag_state_e;

    typedef enum logic {
        PIN_HIGH,
        PIN_LOW
    } pin_state_e;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync
    import irq_flag_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic pin_sync,
    output logic fall
);
    logic [STAGES-1:0] sh;
    pin_state_e        st;
    pin_state_e        st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '1;
        else        sh <= {sh[STAGES-2:0], pin_n};
    end

    assign pin_sync = sh[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= PIN_HIGH;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        fall  = 1'b0;
        unique case (st)
            PIN_HIGH: if (!pin_sync) begin
                st_nx = PIN_LOW;
                fall  = 1'b1;
            end
            PIN_LOW:  if (pin_sync) st_nx = PIN_HIGH;
        endcase
    end

    p_fall_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall)
        else $error("R4: falling-edge pulse lasted more than one cycle");
endmodule

// File: rtl/irq_flag_cell.sv
module irq_flag_cell
    import irq_flag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic wr_en,
    input  logic wr_val,
    input  logic clr,
    input  logic lvl_mode,
    input  logic lvl_val,
    output logic q
);
    flag_state_e st;
    flag_state_e st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= FLAG_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        if (lvl_mode)   st_nx = lvl_val ? FLAG_PEND : FLAG_IDLE;
        else if (set)   st_nx = FLAG_PEND;
        else if (wr_en) st_nx = wr_val ? FLAG_PEND : FLAG_IDLE;
        else if (clr)   st_nx = FLAG_IDLE;
    end

    always_comb begin
        unique case (st)
            FLAG_IDLE: q = 1'b0;
            FLAG_PEND: q = 1'b1;
        endcase
    end

    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (set && !lvl_mode) |=> q)
        else $error("R8: hardware set lost against write or clear");
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
    import irq_flag_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tmr0_ovf,
    input  logic             tmr1_ovf,
    input  logic             ext0_pin_n,
    input  logic             ext1_pin_n,
    input  logic             ext2_req,
    input  logic             ext3_req,
    input  logic             ack_valid,
    input  logic [SRC_W-1:0] ack_src,
    input  logic             sfr_wr_tcon,
    input  logic             sfr_wr_aux,
    input  logic [7:0]       sfr_wdata,
    output logic [7:0]       tcon_q,
    output logic [7:0]       aux_q,
    output logic [NUM_SRC-1:0] irq_req
);
    localparam int NUM_PAIR = 2;

    logic [NUM_SRC-1:0]  ack_hit;
    logic [NUM_SRC-1:0]  flags;
    logic [NUM_PAIR-1:0] pin_n;
    logic [NUM_PAIR-1:0] pin_sync;
    logic [NUM_PAIR-1:0] pin_fall;
    logic [NUM_PAIR-1:0] tmr_ovf;
    logic [NUM_PAIR-1:0] aux_req;
    logic [NUM_PAIR-1:0] edge_mode;
    logic [NUM_PAIR-1:0] run_q;

    assign pin_n   = {ext1_pin_n, ext0_pin_n};
    assign tmr_ovf = {tmr1_ovf, tmr0_ovf};
    assign aux_req = {ext3_req, ext2_req};

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_ack
        assign ack_hit[i] = ack_valid && (ack_src == SRC_W'(i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_mode <= '0;
            run_q     <= '0;
        end else if (sfr_wr_tcon) begin
            edge_mode <= {sfr_wdata[2], sfr_wdata[0]};
            run_q     <= {sfr_wdata[6], sfr_wdata[4]};
        end
    end

    for (genvar g = 0; g < NUM_PAIR; g++) begin : g_pair
        irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_n    (pin_n[g]),
            .pin_sync (pin_sync[g]),
            .fall     (pin_fall[g])
        );

        irq_flag_cell u_ext (
            .clk      (clk),
            .rst_n    (rst_n),
            .set      (pin_fall[g]),
            .wr_en    (sfr_wr_tcon),
            .wr_val   (sfr_wdata[2*g+1]),
            .clr      (ack_hit[2*g]),
            .lvl_mode (!edge_mode[g]),
            .lvl_val  (!pin_sync[g]),
            .q        (flags[2*g])
        );

        irq_flag_cell u_tmr (
            .clk      (clk),
            .rst_n    (rst_n),
            .set      (tmr_ovf[g]),
            .wr_en    (sfr_wr_tcon),
            .wr_val   (sfr_wdata[2*g+5]),
            .clr      (ack_hit[2*g+1]),
            .lvl_mode (1'b0),
            .lvl_val  (1'b0),
            .q        (flags[2*g+1])
        );

        irq_flag_cell u_aux (
            .clk      (clk),
            .rst_n    (rst_n),
            .set      (aux_req[g]),
            .wr_en    (sfr_wr_aux),
            .wr_val   (sfr_wdata[g]),
            .clr      (1'b0),
            .lvl_mode (1'b0),
            .lvl_val  (1'b0),
            .q        (flags[4+g])
        );
    end

    assign tcon_q  = {flags[3], run_q[1], flags[1], run_q[0],
                      flags[2], edge_mode[1], flags[0], edge_mode[0]};
    assign aux_q   = {6'b0, flags[5], flags[4]};
    assign irq_req = flags;

    p_tmr_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tmr0_ovf |=> tcon_q[5])
        else $error("R2: timer 0 overflow did not set its flag");

    p_tmr_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_src == 3'd3 && !tmr1_ovf && !sfr_wr_tcon) |=> !tcon_q[7])
        else $error("R3: timer 1 flag survived its acknowledge");

    p_level_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !tcon_q[0] |=> (tcon_q[1] == !$past(pin_sync[0])))
        else $error("R6: level-mode flag does not follow pin 0");

    p_aux_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext2_req && !sfr_wr_aux) |=> $stable(aux_q[0]))
        else $error("R7: auxiliary flag 2 changed without set or write");
endmodule

// File: tb/irq_flag_ctrl_test.sv
module irq_flag_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tmr0_ovf = 0, tmr1_ovf = 0;
    logic       ext0_pin_n = 1, ext1_pin_n = 1;
    logic       ext2_req = 0, ext3_req = 0;
    logic       ack_valid = 0;
    logic [2:0] ack_src = 0;
    logic       sfr_wr_tcon = 0, sfr_wr_aux = 0;
    logic [7:0] sfr_wdata = 0;
    logic [7:0] tcon_q, aux_q;
    logic [5:0] irq_req;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [7:0] m_tcon, m_aux;
    logic [1:0] m_s1, m_s2, m_hi;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_flag_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf),
        .ext0_pin_n(ext0_pin_n), .ext1_pin_n(ext1_pin_n),
        .ext2_req(ext2_req), .ext3_req(ext3_req),
        .ack_valid(ack_valid), .ack_src(ack_src),
        .sfr_wr_tcon(sfr_wr_tcon), .sfr_wr_aux(sfr_wr_aux),
        .sfr_wdata(sfr_wdata),
        .tcon_q(tcon_q), .aux_q(aux_q), .irq_req(irq_req)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic next_flag(input logic cur, input logic set,
                                       input logic wr, input logic wv, input logic clr);
        if (set)      return 1'b1;
        else if (wr)  return wv;
        else if (clr) return 1'b0;
        return cur;
    endfunction

    function automatic logic [5:0] req_of(input logic [7:0] t, input logic [7:0] a);
        return {a[1], a[0], t[7], t[3], t[5], t[1]};
    endfunction

    task automatic model_reset();
        m_tcon = 8'h00; m_aux = 8'h00; m_s1 = 2'b11; m_s2 = 2'b11; m_hi = 2'b11;
    endtask

    task automatic model_step();
        logic [7:0] nt, na;
        logic [1:0] pins, fall;
        pins = {ext1_pin_n, ext0_pin_n};
        nt = m_tcon; na = m_aux;
        for (int g = 0; g < 2; g++) begin
            fall[g] = m_hi[g] && !m_s2[g];
            if (!m_tcon[2*g]) nt[2*g+1] = !m_s2[g];
            else nt[2*g+1] = next_flag(m_tcon[2*g+1], fall[g], sfr_wr_tcon,
                                       sfr_wdata[2*g+1], ack_valid && ack_src == 3'(2*g));
            nt[2*g+5] = next_flag(m_tcon[2*g+5], g == 0 ? tmr0_ovf : tmr1_ovf, sfr_wr_tcon,
                                  sfr_wdata[2*g+5], ack_valid && ack_src == 3'(2*g+1));
            na[g] = next_flag(m_aux[g], g == 0 ? ext2_req : ext3_req, sfr_wr_aux,
                              sfr_wdata[g], 1'b0);
        end
        if (sfr_wr_tcon) begin
            nt[0] = sfr_wdata[0]; nt[2] = sfr_wdata[2];
            nt[4] = sfr_wdata[4]; nt[6] = sfr_wdata[6];
        end
        m_hi = m_s2; m_s2 = m_s1; m_s1 = pins;
        m_tcon = nt; m_aux = na;
    endtask

    task automatic compare_all();
        check({tcon_q[7], tcon_q[5]} == {m_tcon[7], m_tcon[5]}, "R3 timer flags",
              {tcon_q[7], tcon_q[5]}, {m_tcon[7], m_tcon[5]});
        check({tcon_q[3], tcon_q[1]} == {m_tcon[3], m_tcon[1]}, "R5 external flags",
              {tcon_q[3], tcon_q[1]}, {m_tcon[3], m_tcon[1]});
        check({tcon_q[6], tcon_q[4], tcon_q[2], tcon_q[0]} ==
              {m_tcon[6], m_tcon[4], m_tcon[2], m_tcon[0]}, "R9 storage bits",
              tcon_q, m_tcon);
        check(aux_q == m_aux, "R7 aux register", aux_q, m_aux);
        check(irq_req == req_of(m_tcon, m_aux), "R10 request lines",
              irq_req, req_of(m_tcon, m_aux));
    endtask

    // one clock: inputs already driven; model advances on the same edge
    task automatic tick();
        @(posedge clk);
        model_step();
        #1;
        compare_all();
        @(negedge clk);
        tmr0_ovf = 0; tmr1_ovf = 0; ext2_req = 0; ext3_req = 0;
        ack_valid = 0; sfr_wr_tcon = 0; sfr_wr_aux = 0;
    endtask

    task automatic wr_tcon(input logic [7:0] d);
        sfr_wr_tcon = 1; sfr_wdata = d; tick();
    endtask

    task automatic ack(input logic [2:0] id);
        ack_valid = 1; ack_src = id; tick();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(negedge clk);
        check(tcon_q == 8'h00 && aux_q == 8'h00 && irq_req == 6'h00, "R1 reset state",
              {aux_q, tcon_q}, 0);
        rst_n = 1;

        // R2 timer set, R3 ack clears, invalid IDs do nothing
        tmr0_ovf = 1; tmr1_ovf = 1; tick();
        check(tcon_q[5] && tcon_q[7], "R2 timer overflow set", tcon_q, 8'hA0);
        ack(3'd6); ack(3'd7);
        check(tcon_q[7:5] == 3'b101, "R3 invalid ID keeps flags", tcon_q, 8'hA0);
        ack(3'd1);
        check(!tcon_q[5] && tcon_q[7], "R3 ack ID1 clears TF0 only", tcon_q, 8'h80);

        // R4 edge mode latency and single set; R5 ack clear
        wr_tcon(8'h05);
        ext0_pin_n = 0; tick(); tick();
        check(!tcon_q[1], "R4 flag not set after two edges", tcon_q[1], 0);
        tick();
        check(tcon_q[1], "R4 flag set at third edge", tcon_q[1], 1);
        ack(3'd0);
        check(!tcon_q[1], "R5 edge flag cleared by ack", tcon_q[1], 0);
        repeat (4) tick();
        check(!tcon_q[1], "R4 held-low pin sets only once", tcon_q[1], 0);
        ext0_pin_n = 1; repeat (3) tick();

        // R6 level mode on pin 1
        wr_tcon(8'h01);
        ext1_pin_n = 0; repeat (3) tick();
        check(tcon_q[3], "R6 level flag follows low pin", tcon_q[3], 1);
        ack(3'd2);
        check(tcon_q[3], "R6 ack does not clear level flag", tcon_q[3], 1);
        wr_tcon(8'h01);
        check(tcon_q[3], "R6 write does not clear level flag", tcon_q[3], 1);
        ext1_pin_n = 1; repeat (3) tick();
        check(!tcon_q[3], "R6 level flag drops with pin", tcon_q[3], 0);

        // R8 set beats write and ack
        tmr0_ovf = 1; ack_valid = 1; ack_src = 3'd1; sfr_wr_tcon = 1; sfr_wdata = 8'h01;
        tick();
        check(tcon_q[5], "R8 set wins over write and ack", tcon_q[5], 1);

        // R7 aux flags
        ext2_req = 1; ext3_req = 1; tick();
        ack(3'd4); ack(3'd5);
        check(aux_q == 8'h03, "R7 aux flags ignore ack", aux_q, 8'h03);
        sfr_wr_aux = 1; sfr_wdata = 8'hFE; tick();
        check(aux_q == 8'h02, "R7 write clears aux flag", aux_q, 8'h02);
        sfr_wr_aux = 1; sfr_wdata = 8'hFF; tick();
        check(aux_q == 8'h03, "R7 unused bits read zero", aux_q, 8'h03);

        // constrained random
        for (int n = 0; n < 4000; n++) begin
            r = $urandom;
            tmr0_ovf    = (r[2:0] == 0);
            tmr1_ovf    = (r[5:3] == 0);
            if (r[8:6] == 0)  ext0_pin_n = ~ext0_pin_n;
            if (r[11:9] == 0) ext1_pin_n = ~ext1_pin_n;
            ext2_req    = (r[14:12] == 0);
            ext3_req    = (r[17:15] == 0);
            ack_valid   = (r[19:18] == 0);
            ack_src     = r[22:20];
            sfr_wr_tcon = (r[26:23] == 0);
            sfr_wr_aux  = (r[30:27] == 0);
            sfr_wdata   = 8'($urandom);
            tick();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule